// File: doc/BRIEF.md
# Prescaled 8-bit timer/counter

The block is an 8-bit up-counter that advances by one on each timer tick. A 3-bit select input chooses where ticks come from. Code 000 stops the counter. Codes 001 to 101 pick one tap of a free-running prescaler driven by the system clock. Codes 110 and 111 count edges seen on an external count input.

Software presets the count through a write strobe and a data bus. The current count is always visible on the read bus. Counting resumes from the written value on the next tick. When the count wraps from 255 to 0, a one-cycle overflow pulse is raised.

The external input is sampled as it stands on the pin, so any source driving that pin can clock the counter, including the chip itself. It passes through a two-flop synchronizer and an edge detector before it reaches the counter.

Top module: `tmr8_top`

## Requirements
- R1: While rst_ni is low and right after it rises, rd_data_o is 0 and ovf_o is 0.
- R2: With sel_i = 000 and no write, the count holds its value, whatever the prescaler or ext_i does.
- R3: Select codes 001, 010, 011, 100 and 101 give one tick every 1, 8, 64, 256 and 1024 system clock cycles. The prescaler runs freely and is not reset when sel_i changes, so over any window of a whole number of tap periods the count rises by the window length divided by the tap period.
- R4: Select code 111 counts each rising edge of ext_i. Select code 110 counts each falling edge. An edge applied before a clock edge appears on rd_data_o after the third clock edge and not after the second.
- R5: When wr_en_i is high at a clock edge, rd_data_o takes wr_data_i at that edge. This holds for every select code. Incrementing resumes from the written value on the next tick.
- R6: A tick that coincides with a write is dropped. The written value is loaded unchanged.
- R7: Each tick adds exactly one, modulo 256. The count never decreases except by a write or by wrapping.
- R8: ovf_o is high for exactly the one cycle in which rd_data_o has just wrapped from 255 to 0 through a tick. A write never raises ovf_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 3 | Tick source select (000 stop, 001..101 prescaler taps, 110 falling edges, 111 rising edges) |
| ext_i | input | 1 | External count input |
| wr_en_i | input | 1 | Count write strobe |
| wr_data_i | input | 8 | Value to preset |
| rd_data_o | output | 8 | Current count |
| ovf_o | output | 1 | One-cycle wrap pulse |

## Verification
The checker verifies on every cycle that:
- a stopped counter holds its value;
- a write loads its data at the next edge;
- the count moves by at most one without a write, and by exactly one per cycle on the undivided tap;
- every overflow pulse sits on a zero count reached from 255.

Only the bench scenarios can show the actual tap rates, because these need windows of many cycles. The same holds for the three-edge latency and the edge polarity of external counting, for the dropped tick when a write coincides with a tick, and for the absence of a pulse when a write lands on 255.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  localparam int unsigned CNT_W    = 8;
  localparam int unsigned SEL_W    = 3;
  localparam int unsigned NUM_TAPS = 5;
  // low prescaler bits that must be all ones for each tap (div 1,8,64,256,1024)
  localparam int unsigned TAP_BITS [NUM_TAPS] = '{0, 3, 6, 8, 10};
  localparam int unsigned PRE_W    = TAP_BITS[NUM_TAPS-1];

  localparam logic [SEL_W-1:0] SEL_STOP = 3'b000;
  localparam logic [SEL_W-1:0] SEL_FALL = 3'b110;
  localparam logic [SEL_W-1:0] SEL_RISE = 3'b111;
endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler
  import tmr8_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic [NUM_TAPS-1:0] tap_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= '0;
    else         pre_q <= pre_q + 1'b1;
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
    if (TAP_BITS[k] == 0) begin : g_div1
      assign tap_o[k] = 1'b1;
    end else begin : g_divn
      assign tap_o[k] = &pre_q[TAP_BITS[k]-1:0];
    end
  end
endmodule

// File: rtl/tmr8_ext_edge.sv
module tmr8_ext_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  output logic rise_o,
  output logic fall_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_i};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o =  sync_q[SYNC_STAGES-1] & ~prev_q;
  assign fall_o = ~sync_q[SYNC_STAGES-1] &  prev_q;
endmodule

// File: rtl/tmr8_tick_sel.sv
module tmr8_tick_sel
  import tmr8_pkg::*;
(
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [NUM_TAPS-1:0] tap_i,
  input  logic                rise_i,
  input  logic                fall_i,
  output logic                tick_o
);
  always_comb begin
    tick_o = 1'b0;
    if (sel_i == SEL_RISE)      tick_o = rise_i;
    else if (sel_i == SEL_FALL) tick_o = fall_i;
    else begin
      for (int k = 0; k < NUM_TAPS; k++)
        if (sel_i == SEL_W'(k + 1)) tick_o = tap_i[k];
    end
  end
endmodule

// File: rtl/tmr8_core.sv
module tmr8_core
  import tmr8_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (wr_en_i) begin
        cnt_q <= wr_data_i;  // write wins over a coincident tick
      end else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        ovf_q <= &cnt_q;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/tmr8_top.sv
module tmr8_top
  import tmr8_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             ext_i,
  input  logic             wr_en_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             ovf_o
);
  logic [NUM_TAPS-1:0] tap;
  logic                rise, fall, tick;

  tmr8_prescaler u_pre (.clk_i(clk_i), .rst_ni(rst_ni), .tap_o(tap));

  tmr8_ext_edge #(.SYNC_STAGES(2)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_i(ext_i), .rise_o(rise), .fall_o(fall)
  );

  tmr8_tick_sel u_sel (
    .sel_i(sel_i), .tap_i(tap), .rise_i(rise), .fall_i(fall), .tick_o(tick)
  );

  tmr8_core u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .wr_en_i(wr_en_i),
    .wr_data_i(wr_data_i), .cnt_o(rd_data_o), .ovf_o(ovf_o)
  );
endmodule

// File: rtl/tmr8_chk.sv
module tmr8_chk
  import tmr8_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [SEL_W-1:0] sel_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] wr_data_i,
  input logic [CNT_W-1:0] rd_data_o,
  input logic             ovf_o
);
  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (rd_data_o == '0 && !ovf_o));

  assert_stop_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_STOP && !wr_en_i) |=> $stable(rd_data_o));

  assert_div1_every_cycle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == SEL_W'(1) && !wr_en_i) |=> rd_data_o == $past(rd_data_o) + 1'b1);

  assert_write_loads_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> rd_data_o == $past(wr_data_i));

  assert_step_one_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> (rd_data_o == $past(rd_data_o) || rd_data_o == $past(rd_data_o) + 1'b1));

  assert_ovf_on_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (rd_data_o == '0 && $past(rd_data_o) == '1 && !$past(wr_en_i)));

  assert_ovf_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);
endmodule

bind tmr8_top tmr8_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .ovf_o(ovf_o)
);

// File: tb/tmr8_top_test.sv
`timescale 1ns/1ps
module tmr8_top_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] sel_i = 3'b000;
  logic       ext_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       ovf_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  tmr8_top uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic preset(input logic [7:0] v);
    wr_en_i = 1'b1; wr_data_i = v;
    step(1);
    wr_en_i = 1'b0;
  endtask

  // counts ticks of one select code over a window of w clock edges
  task automatic window(input logic [2:0] code, input int w, input int exp, input string req);
    sel_i = 3'b000;
    preset(8'h00);
    sel_i = code;
    step(w);
    sel_i = 3'b000;
    chk(req, rd_data_o, exp % 256);
  endtask

  task automatic pulses(input logic [2:0] code, input int n, input string req);
    sel_i = 3'b000;
    ext_i = 1'b0;
    step(4);
    preset(8'h00);
    sel_i = code;
    for (int i = 0; i < n; i++) begin
      ext_i = 1'b1; step(4);
      ext_i = 1'b0; step(4);
    end
    sel_i = 3'b000;
    chk(req, rd_data_o, n);
  endtask

  initial begin
    int period;
    step(3);
    chk("R1 count in reset", rd_data_o, 0);
    chk("R1 ovf in reset", ovf_o, 0);
    rst_ni = 1'b1;
    step(2);
    chk("R1 count after reset", rd_data_o, 0);
    chk("R1 ovf after reset", ovf_o, 0);

    // R3: tap sweep
    window(3'b001, 100, 100, "R3 div1");
    window(3'b010, 1024, 128, "R3 div8");
    window(3'b011, 1024, 16, "R3 div64");
    window(3'b100, 1024, 4, "R3 div256");
    window(3'b101, 2048, 2, "R3 div1024");
    for (int k = 2; k <= 5; k++) begin
      period = (k == 2) ? 8 : (k == 3) ? 64 : (k == 4) ? 256 : 1024;
      window(3'(k), 2 * period, 2, "R3 two periods");
    end

    // R2: stop holds while ext toggles
    sel_i = 3'b000;
    preset(8'h5A);
    for (int i = 0; i < 20; i++) begin
      ext_i = ~ext_i; step(3);
    end
    ext_i = 1'b0;
    step(1200);
    chk("R2 stop holds", rd_data_o, 8'h5A);

    // R4: edge counting and polarity
    pulses(3'b111, 5, "R4 rising edges");
    pulses(3'b110, 7, "R4 falling edges");
    sel_i = 3'b000; ext_i = 1'b0; step(4);
    preset(8'h00);
    sel_i = 3'b111;
    ext_i = 1'b1;
    step(2);
    chk("R4 latency two edges", rd_data_o, 0);
    step(1);
    chk("R4 latency three edges", rd_data_o, 1);
    ext_i = 1'b0;
    step(4);
    chk("R4 rising ignores fall", rd_data_o, 1);

    // R5/R6: preset during counting
    sel_i = 3'b001;
    wr_en_i = 1'b1; wr_data_i = 8'h50;
    step(1);
    wr_en_i = 1'b0;
    chk("R6 write beats tick", rd_data_o, 8'h50);
    step(1);
    chk("R5 resumes from preset", rd_data_o, 8'h51);
    sel_i = 3'b000;
    preset(8'hC3);
    chk("R5 write while stopped", rd_data_o, 8'hC3);

    // R7/R8: wrap and overflow pulse
    sel_i = 3'b001;
    preset(8'hFE);
    chk("R7 preset FE", rd_data_o, 8'hFE);
    chk("R8 no ovf at FE", ovf_o, 0);
    step(1);
    chk("R7 to FF", rd_data_o, 8'hFF);
    chk("R8 no ovf at FF", ovf_o, 0);
    step(1);
    chk("R7 wrap to 0", rd_data_o, 0);
    chk("R8 ovf at wrap", ovf_o, 1);
    step(1);
    chk("R7 after wrap", rd_data_o, 1);
    chk("R8 ovf one cycle", ovf_o, 0);

    preset(8'hFF);
    wr_en_i = 1'b1; wr_data_i = 8'h10;
    step(1);
    wr_en_i = 1'b0;
    chk("R6 write at FF", rd_data_o, 8'h10);
    chk("R8 no ovf on write", ovf_o, 0);
    sel_i = 3'b000;
    step(2);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule